// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block sits beside the fetch stage of a small 8-bit core and runs the steps of interrupt entry and interrupt return. Eight request lines are sampled when the core reports an instruction boundary. The lowest-numbered pending request wins. The sequencer stalls the core and reads that request's handler address from the matching word at the very bottom of program memory. It saves the address after the interrupted instruction to the return-address stack. It then either redirects the instruction pointer to the handler or, when the stored handler address is zero, halts the core.

While a handler runs, the block holds a handler-mode flag. A handler-return instruction pops the saved address and resumes there, and the flag clears in the cycle the core is redirected. A return executed outside a handler is turned into a request on line 0, the invalid-instruction source. Any request that arrives while the flag is set is a double fault. Normally the sequencer resets the core and restarts it at address 8. If the debug-hold input is high, it halts the core instead, so the state can be inspected. Program memory and the return-address stack are both reached through plain ports whose read data is valid one cycle after the request.

Top module: `irq_entry_seq`

## Requirements
- R1: A clock edge with `rst` high sets `ip_load`=1, `ip_value`=8, and `in_handler`, `halt`, `stall`, `core_reset`, `pm_rd_en`, `ras_push` and `ras_pop` all to 0. The first edge with `rst` low returns `ip_load` to 0.
- R2: Requests are taken only at an edge where `insn_boundary`=1. With `insn_boundary`=0, pending requests start no memory read, no stall and no push.
- R3: When several bits of `irq_req` are set at a taken boundary, the lowest-numbered one is served. In the cycle after the take, `pm_rd_en`=1 for exactly one cycle and `pm_rd_addr` equals that number (program words 0 to 7 hold the handler addresses of lines 0 to 7).
- R4: In the cycle after the take, `ras_push`=1 for exactly one cycle, with `ras_push_data` = `cur_addr`+1 (modulo 2^16).
- R5: `pm_rd_data` is sampled one cycle after `pm_rd_en`. If it is nonzero, the following cycle shows `ip_load`=1 with `ip_value` equal to it, and `in_handler`=1 from that cycle on. `stall` is 1 from the cycle after the take up to, but not including, that cycle.
- R6: If the fetched handler address is 0, the core halts: `halt`=1 and `ip_load` stays 0.
- R7: A request taken at a boundary while `in_handler`=1 and `dbg_hold`=0 gives, in the next cycle, `core_reset`=1 for one cycle, together with `ip_load`=1, `ip_value`=8 and `in_handler`=0.
- R8: The same double fault with `dbg_hold`=1 sets `halt`=1 and leaves `core_reset`=0.
- R9: `ire_exec` at a boundary while `in_handler`=1 and no request is pending pulses `ras_pop` for one cycle after the edge. The popped address arrives one cycle later. The cycle after that shows `ip_load`=1 with `ip_value` equal to the popped address, and `in_handler` clears in that same cycle.
- R10: `ire_exec` at a boundary while `in_handler`=0 is served as a request on line 0: `pm_rd_addr`=0, and the entry proceeds as in R4 and R5.
- R11: Once `halt`=1, it stays 1 until `rst`, and all requests, boundaries and returns are ignored (no `pm_rd_en`, no `ip_load`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 8 | Request lines, bit n = source n |
| insn_boundary | input | 1 | Core is between instructions this cycle |
| cur_addr | input | 16 | Address of the current instruction |
| ire_exec | input | 1 | Handler-return instruction executes this cycle |
| dbg_hold | input | 1 | Halt instead of reset on a double fault |
| pm_rd_en | output | 1 | Program-memory read strobe |
| pm_rd_addr | output | 16 | Program-memory read address |
| pm_rd_data | input | 16 | Program-memory read data, one cycle after the strobe |
| ras_push | output | 1 | Push strobe to the return-address stack |
| ras_push_data | output | 16 | Return address to push |
| ras_pop | output | 1 | Pop strobe to the return-address stack |
| ras_pop_data | input | 16 | Popped address, one cycle after the strobe |
| ip_load | output | 1 | Load the instruction pointer this cycle |
| ip_value | output | 16 | New instruction pointer value |
| stall | output | 1 | Freeze the pipeline |
| halt | output | 1 | Core halted, sticky until reset |
| core_reset | output | 1 | One-cycle reset request to the core |
| in_handler | output | 1 | Handler mode active |

## Verification
Some properties are checked by assertions on every cycle. These are the single-cycle width of the push, read and reset pulses; the rule that a redirect never shows together with a stall; the persistence of a halt; the halt that follows a zero handler address; the rule that a granted line is always actually pending; and the set and clear of the handler flag. Other behaviour can only be shown by the bench's scenarios. That covers which line wins for a given request pattern, the exact read address, the return value pushed (including the wrap at the top of the address space), the handler address reached, the round trip through the stack on return, and the split between reset and halt on a double fault.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_VREQ = 3'd1,
    ST_VDEC = 3'd2,
    ST_RREQ = 3'd3,
    ST_RDEC = 3'd4,
    ST_HALT = 3'd5
  } seq_state_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N   = 8,
  parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   req,
  output logic           any,
  output logic [IDW-1:0] id
);
  logic [N-1:0] below;
  logic [N-1:0] win;

  assign below[0] = 1'b0;
  generate
    for (genvar i = 1; i < N; i++) begin : g_chain
      assign below[i] = below[i-1] | req[i-1];
    end
  endgenerate

  assign win = req & ~below;
  assign any = |req;

  always_comb begin
    id = '0;
    for (int k = 0; k < N; k++) begin
      if (win[k]) id = IDW'(k);
    end
  end

  // R3: the granted line must be pending and nothing below it may be
  always_comb begin
    if (any) begin
      a_r3_grant_valid: assert (req[id] && (win == (N'(1) << id)));
    end
  end
endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic active
);
  always_ff @(posedge clk) begin
    if (rst)      active <= 1'b0;
    else if (clr) active <= 1'b0;
    else if (set) active <= 1'b1;
  end

  a_r5_enter_sets: assert property (@(posedge clk) disable iff (rst)
    (set && !clr) |=> active);
  a_r9_exit_clears: assert property (@(posedge clk) disable iff (rst)
    clr |=> !active);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int ADDR_W    = 16,
  parameter int RESET_VEC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               insn_boundary,
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic               ire_exec,
  input  logic               dbg_hold,
  output logic               pm_rd_en,
  output logic [ADDR_W-1:0]  pm_rd_addr,
  input  logic [ADDR_W-1:0]  pm_rd_data,
  output logic               ras_push,
  output logic [ADDR_W-1:0]  ras_push_data,
  output logic               ras_pop,
  input  logic [ADDR_W-1:0]  ras_pop_data,
  output logic               ip_load,
  output logic [ADDR_W-1:0]  ip_value,
  output logic               stall,
  output logic               halt,
  output logic               core_reset,
  output logic               in_handler
);
  localparam int IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [ADDR_W-1:0] BOOT_ADDR = ADDR_W'(RESET_VEC);

  seq_state_e         state;
  logic [NUM_IRQ-1:0] req_eff;
  logic               req_any;
  logic [IDW-1:0]     req_id;
  logic               take;
  logic               dbl_fault;
  logic               ret_go;
  logic               mode_set;
  logic               mode_clr;
  logic               vec_zero;

  // a return outside a handler is an invalid instruction on line 0
  always_comb begin
    req_eff    = irq_req;
    req_eff[0] = irq_req[0] | (ire_exec & ~in_handler);
  end

  irq_prio_enc #(.N(NUM_IRQ), .IDW(IDW)) u_prio (
    .req (req_eff),
    .any (req_any),
    .id  (req_id)
  );

  assign take      = (state == ST_IDLE) && insn_boundary;
  assign dbl_fault = take && req_any && in_handler;
  assign ret_go    = take && !req_any && ire_exec && in_handler;
  assign vec_zero  = (pm_rd_data == '0);
  assign mode_set  = (state == ST_VDEC) && !vec_zero;
  assign mode_clr  = (state == ST_RDEC) || (dbl_fault && !dbg_hold);

  irq_mode_reg u_mode (
    .clk    (clk),
    .rst    (rst),
    .set    (mode_set),
    .clr    (mode_clr),
    .active (in_handler)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      ip_load       <= 1'b1;
      ip_value      <= BOOT_ADDR;
      pm_rd_en      <= 1'b0;
      pm_rd_addr    <= '0;
      ras_push      <= 1'b0;
      ras_push_data <= '0;
      ras_pop       <= 1'b0;
      stall         <= 1'b0;
      halt          <= 1'b0;
      core_reset    <= 1'b0;
    end else begin
      ip_load    <= 1'b0;
      pm_rd_en   <= 1'b0;
      ras_push   <= 1'b0;
      ras_pop    <= 1'b0;
      core_reset <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (dbl_fault) begin
            if (dbg_hold) begin
              halt  <= 1'b1;
              state <= ST_HALT;
            end else begin
              core_reset <= 1'b1;
              ip_load    <= 1'b1;
              ip_value   <= BOOT_ADDR;
            end
          end else if (take && req_any) begin
            pm_rd_en      <= 1'b1;
            pm_rd_addr    <= ADDR_W'(req_id);
            ras_push      <= 1'b1;
            ras_push_data <= cur_addr + 1'b1;
            stall         <= 1'b1;
            state         <= ST_VREQ;
          end else if (ret_go) begin
            ras_pop <= 1'b1;
            stall   <= 1'b1;
            state   <= ST_RREQ;
          end
        end
        ST_VREQ: state <= ST_VDEC;
        ST_VDEC: begin
          stall <= 1'b0;
          if (vec_zero) begin
            halt  <= 1'b1;
            state <= ST_HALT;
          end else begin
            ip_load  <= 1'b1;
            ip_value <= pm_rd_data;
            state    <= ST_IDLE;
          end
        end
        ST_RREQ: state <= ST_RDEC;
        ST_RDEC: begin
          stall    <= 1'b0;
          ip_load  <= 1'b1;
          ip_value <= ras_pop_data;
          state    <= ST_IDLE;
        end
        ST_HALT: state <= ST_HALT;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r4_push_single: assert property (@(posedge clk) disable iff (rst)
    ras_push |=> !ras_push);
  a_r3_read_single: assert property (@(posedge clk) disable iff (rst)
    pm_rd_en |=> !pm_rd_en);
  a_r5_load_unstalled: assert property (@(posedge clk) disable iff (rst)
    ip_load |-> !stall);
  a_r6_zero_halts: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VDEC && pm_rd_data == '0) |=> (halt && !ip_load));
  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halt |=> (halt && !ip_load && !pm_rd_en));
  a_r7_reset_pulse: assert property (@(posedge clk) disable iff (rst)
    core_reset |-> (ip_load && ip_value == BOOT_ADDR && !in_handler));
  a_r7_reset_single: assert property (@(posedge clk) disable iff (rst)
    core_reset |=> !core_reset);
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  localparam int CLK_P = 10;
  localparam int NI    = 8;
  localparam int AW    = 16;
  // row: {request pattern, current address, expected winning line}
  localparam logic [26:0] TBL [8] = '{
    {8'b0000_0001, 16'h0040, 3'd0},
    {8'b1000_0000, 16'h1234, 3'd7},
    {8'b1100_1000, 16'h00FF, 3'd3},
    {8'b0000_0110, 16'hFFFE, 3'd1},
    {8'b0101_0100, 16'h2000, 3'd2},
    {8'b0100_0000, 16'h0808, 3'd6},
    {8'b1001_0000, 16'h7777, 3'd4},
    {8'b1000_0010, 16'hFFFF, 3'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NI-1:0] irq_req = '0;
  logic insn_boundary = 1'b0;
  logic [AW-1:0] cur_addr = '0;
  logic ire_exec = 1'b0;
  logic dbg_hold = 1'b0;
  logic pm_rd_en, ras_push, ras_pop, ip_load, stall, halt, core_reset, in_handler;
  logic [AW-1:0] pm_rd_addr, ras_push_data, ip_value;
  logic [AW-1:0] pm_rd_data = '0;
  logic [AW-1:0] ras_pop_data = '0;
  logic [AW-1:0] vmem [8];
  logic [AW-1:0] stk [16];
  logic [3:0] sp;
  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .insn_boundary(insn_boundary),
    .cur_addr(cur_addr), .ire_exec(ire_exec), .dbg_hold(dbg_hold),
    .pm_rd_en(pm_rd_en), .pm_rd_addr(pm_rd_addr), .pm_rd_data(pm_rd_data),
    .ras_push(ras_push), .ras_push_data(ras_push_data), .ras_pop(ras_pop),
    .ras_pop_data(ras_pop_data), .ip_load(ip_load), .ip_value(ip_value),
    .stall(stall), .halt(halt), .core_reset(core_reset), .in_handler(in_handler)
  );

  function automatic logic [AW-1:0] vec_of(input int n);
    return (n == 5) ? 16'h0000 : 16'h0100 + AW'(n * 16);
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) vmem[i] = vec_of(i);
  end

  always_ff @(posedge clk) begin
    if (pm_rd_en) pm_rd_data <= vmem[pm_rd_addr[2:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else if (ras_push) begin
      stk[sp] <= ras_push_data;
      sp <= sp + 1'b1;
    end else if (ras_pop) begin
      ras_pop_data <= stk[sp - 1'b1];
      sp <= sp - 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    irq_req = '0; insn_boundary = 1'b0; ire_exec = 1'b0; cur_addr = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    clear_in();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // starts and ends at a negedge; full entry with checks
  task automatic enter(input logic [NI-1:0] rq, input logic ire, input logic [AW-1:0] ca,
                       input int id);
    irq_req = rq; ire_exec = ire; insn_boundary = 1'b1; cur_addr = ca;
    @(negedge clk);
    chk("R3 rd_en", 32'(pm_rd_en), 1);
    chk("R3 rd_addr", 32'(pm_rd_addr), 32'(id));
    chk("R4 push", 32'(ras_push), 1);
    chk("R4 push_data", 32'(ras_push_data), 32'(AW'(ca + 1'b1)));
    chk("R5 stall", 32'(stall), 1);
    clear_in();
    @(negedge clk);
    chk("R4 push_once", 32'(ras_push), 0);
    chk("R5 stall_hold", 32'(stall), 1);
    @(negedge clk);
    chk("R5 ip_load", 32'(ip_load), 1);
    chk("R5 ip_value", 32'(ip_value), 32'(vec_of(id)));
    chk("R5 in_handler", 32'(in_handler), 1);
    chk("R5 stall_off", 32'(stall), 0);
  endtask

  task automatic leave(input logic [AW-1:0] ret);
    ire_exec = 1'b1; insn_boundary = 1'b1;
    @(negedge clk);
    chk("R9 pop", 32'(ras_pop), 1);
    chk("R9 no_read", 32'(pm_rd_en), 0);
    clear_in();
    @(negedge clk);
    chk("R9 pop_once", 32'(ras_pop), 0);
    @(negedge clk);
    chk("R9 ip_load", 32'(ip_load), 1);
    chk("R9 ip_value", 32'(ip_value), 32'(ret));
    chk("R9 mode_clear", 32'(in_handler), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ip_load", 32'(ip_load), 1);
    chk("R1 ip_value", 32'(ip_value), 8);
    chk("R1 quiet", {28'd0, in_handler, halt, stall, core_reset}, 0);
    chk("R1 strobes", {29'd0, pm_rd_en, ras_push, ras_pop}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 load_drop", 32'(ip_load), 0);

    // R2: no boundary, no take
    irq_req = 8'h18;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R2 ignored", {29'd0, pm_rd_en, stall, ras_push}, 0);
    end
    clear_in();

    // R3 R4 R5 R9: table of entries, each followed by a return
    for (int r = 0; r < 8; r++) begin
      enter(TBL[r][26:19], 1'b0, TBL[r][18:3], int'(TBL[r][2:0]));
      leave(TBL[r][18:3] + 1'b1);
    end

    // R10: return outside a handler becomes line 0
    enter(8'h00, 1'b1, 16'h0456, 0);
    leave(16'h0457);

    // R7: double fault resets
    enter(8'h08, 1'b0, 16'h0300, 3);
    irq_req = 8'h10; insn_boundary = 1'b1;
    @(negedge clk);
    clear_in();
    chk("R7 core_reset", 32'(core_reset), 1);
    chk("R7 ip_load", 32'(ip_load), 1);
    chk("R7 ip_value", 32'(ip_value), 8);
    chk("R7 mode_clear", 32'(in_handler), 0);
    @(negedge clk);
    chk("R7 pulse_once", 32'(core_reset), 0);

    // R8 R11: double fault under debug hold halts
    enter(8'h40, 1'b0, 16'h0500, 6);
    dbg_hold = 1'b1;
    irq_req = 8'h01; insn_boundary = 1'b1;
    @(negedge clk);
    chk("R8 halt", 32'(halt), 1);
    chk("R8 no_reset", 32'(core_reset), 0);
    dbg_hold = 1'b0;
    ire_exec = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R11 halted", {29'd0, halt, pm_rd_en, ip_load}, 32'b100);
    end
    do_reset();

    // R6: zero handler address halts
    irq_req = 8'h20; insn_boundary = 1'b1; cur_addr = 16'h0600;
    @(negedge clk);
    chk("R6 rd_addr", 32'(pm_rd_addr), 5);
    clear_in();
    @(negedge clk);
    @(negedge clk);
    chk("R6 halt", 32'(halt), 1);
    chk("R6 no_load", 32'(ip_load), 0);
    chk("R6 no_mode", 32'(in_handler), 0);
    insn_boundary = 1'b1; irq_req = 8'h01;
    @(negedge clk);
    chk("R11 stays", {30'd0, halt, pm_rd_en}, 32'b10);
    do_reset();
    chk("R1 after_rst", 32'(halt), 0);

    summary();
    $finish;
  end
endmodule